// File: doc/BRIEF.md
# DVFS Schedule Table Lookup Unit

This unit picks a voltage/frequency level for every task of a task graph whose mapping onto processors was fixed offline. Before a run, software fills a small table. Each task has a row of up to K entries, and each entry pairs a breakpoint with a level. The breakpoint is counted in cycles elapsed along the task's predecessor paths. Software also loads, for each task, a mask of the tasks it depends on.

At run time the unit receives two kinds of event. A ready event says that a task is being dispatched. A done event reports how many cycles a finished task actually consumed. For each task the unit keeps the sum of its elapsed count and its reported workload. When a task becomes ready, its elapsed count is the largest such sum over its predecessors. The unit then searches that task's row and returns a level index one cycle later.

Levels are numbered 0 to 6. Level 0 is the fastest setting, and it is the fallback whenever no entry covers the measured count. A frame-start pulse clears the per-task done and active flags so that the graph can run again.

Top module: `dvfs_sched_lut`

## Requirements
- R1: After reset, lvl_valid is 0, every table row and predecessor mask is empty, and no task is active.
- R2: A level index is 3 bits wide, with 0 the fastest and 6 the slowest. A table write whose level is 7 or more is ignored.
- R3: A ready task whose predecessor mask is empty sees an elapsed count of 0.
- R4: A ready task's elapsed count is the maximum, over the tasks set in its predecessor mask, of that predecessor's elapsed count plus its reported cycles. Each of these sums saturates at 2^CW-1.
- R5: A done event for an active task records its sum and makes the task inactive. A done event for a task that is not active is ignored.
- R6: A ready event whose predecessors have all reported done gives, on the next cycle, a one-cycle lvl_valid together with lvl_task, lvl_out and elapsed_out. If any predecessor has not reported done, the ready event produces no output and activates nothing.
- R7: The selected entry is the loaded entry in the task's row with the smallest breakpoint not less than the elapsed count. When breakpoints tie, the lower slot number wins.
- R8: If the elapsed count exceeds every loaded breakpoint, or the row has no loaded entry, level 0 is output.
- R9: Table writes and predecessor-mask writes are ignored while any task is active.
- R10: frame_go clears every task's done and active flags. After it, a task with predecessors cannot be dispatched until those predecessors report done again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_task | input | TW | Row (task) being written |
| tbl_slot | input | SW | Entry slot within the row |
| tbl_ce | input | CW | Elapsed-cycle breakpoint |
| tbl_lvl | input | LW | Level index for the entry |
| pred_we | input | 1 | Predecessor mask write strobe |
| pred_task | input | TW | Task whose mask is written |
| pred_mask | input | NT | One bit per predecessor task |
| frame_go | input | 1 | Start a new graph iteration |
| rdy_valid | input | 1 | Task ready (dispatch) event |
| rdy_task | input | TW | Id of the ready task |
| done_valid | input | 1 | Task completion event |
| done_task | input | TW | Id of the finished task |
| done_cycles | input | CW | Cycles consumed by the finished task |
| lvl_valid | output | 1 | Level result valid (one cycle) |
| lvl_task | output | TW | Task the result belongs to |
| lvl_out | output | LW | Selected level index |
| elapsed_out | output | CW | Elapsed count used for the lookup |

## Verification
On every cycle, the assertions check four things:
- a result appears only on the cycle after a ready event, and it names the same task;
- the returned level index lies within the legal range;
- the table contents do not change when a write arrives while a task is active;
- a done event clears the active flag of the task it names.

Other behaviours need the bench's scenarios, because only a sequence of events can show them:
- the max-of-sums rule at a join and its saturation;
- the choice of the nearest breakpoint at or above the elapsed count, including ties and the fallback to level 0;
- a ready event blocked by an unfinished predecessor;
- the effect of frame_go.

// File: rtl/dvfs_sched_lut.sv
module dvfs_sched_lut #(
  parameter int NT   = 4,
  parameter int K    = 4,
  parameter int CW   = 12,
  parameter int NLVL = 7,
  parameter int LW   = $clog2(NLVL),
  parameter int TW   = $clog2(NT),
  parameter int SW   = $clog2(K)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tbl_we,
  input  logic [TW-1:0] tbl_task,
  input  logic [SW-1:0] tbl_slot,
  input  logic [CW-1:0] tbl_ce,
  input  logic [LW-1:0] tbl_lvl,
  input  logic          pred_we,
  input  logic [TW-1:0] pred_task,
  input  logic [NT-1:0] pred_mask,
  input  logic          frame_go,
  input  logic          rdy_valid,
  input  logic [TW-1:0] rdy_task,
  input  logic          done_valid,
  input  logic [TW-1:0] done_task,
  input  logic [CW-1:0] done_cycles,
  output logic          lvl_valid,
  output logic [TW-1:0] lvl_task,
  output logic [LW-1:0] lvl_out,
  output logic [CW-1:0] elapsed_out
);
  logic [NT-1:0][K-1:0][CW-1:0] bp;
  logic [NT-1:0][K-1:0][LW-1:0] lv;
  logic [NT-1:0][K-1:0]         ev;
  logic [NT-1:0][NT-1:0]        pm;
  logic [NT-1:0][CW-1:0]        el, fin;
  logic [NT-1:0]                act, dn;

  wire busy = |act;
  wire lvl_ok = {1'b0, tbl_lvl} < (LW+1)'(NLVL);

  logic [CW-1:0] join_el, pick_bp;
  logic [LW-1:0] pick_lv;
  logic          preds_ok, found;

  always_comb begin
    join_el  = '0;
    preds_ok = 1'b1;
    for (int p = 0; p < NT; p++)
      if (pm[rdy_task][p]) begin
        if (!dn[p]) preds_ok = 1'b0;
        if (fin[p] > join_el) join_el = fin[p];
      end
  end

  always_comb begin
    found   = 1'b0;
    pick_bp = '0;
    pick_lv = '0;
    for (int k = 0; k < K; k++)
      if (ev[rdy_task][k] && bp[rdy_task][k] >= join_el &&
          (!found || bp[rdy_task][k] < pick_bp)) begin
        found   = 1'b1;
        pick_bp = bp[rdy_task][k];
        pick_lv = lv[rdy_task][k];
      end
  end

  wire [CW:0]   sum     = {1'b0, el[done_task]} + {1'b0, done_cycles};
  wire [CW-1:0] sum_sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bp <= '0; lv <= '0; ev <= '0; pm <= '0;
      el <= '0; fin <= '0; act <= '0; dn <= '0;
      lvl_valid <= 1'b0; lvl_task <= '0; lvl_out <= '0; elapsed_out <= '0;
    end else begin
      lvl_valid <= 1'b0;
      if (tbl_we && !busy && lvl_ok) begin
        bp[tbl_task][tbl_slot] <= tbl_ce;
        lv[tbl_task][tbl_slot] <= tbl_lvl;
        ev[tbl_task][tbl_slot] <= 1'b1;
      end
      if (pred_we && !busy) pm[pred_task] <= pred_mask;
      if (frame_go) begin
        act <= '0;
        dn  <= '0;
      end else begin
        if (done_valid && act[done_task]) begin
          fin[done_task] <= sum_sat;
          dn[done_task]  <= 1'b1;
          act[done_task] <= 1'b0;
        end
        if (rdy_valid && preds_ok) begin
          el[rdy_task]  <= join_el;
          act[rdy_task] <= 1'b1;
          lvl_valid     <= 1'b1;
          lvl_task      <= rdy_task;
          lvl_out       <= pick_lv;
          elapsed_out   <= join_el;
        end
      end
    end
  end
endmodule

// File: rtl/dvfs_sched_lut_chk.sv
module dvfs_sched_lut_chk #(
  parameter int NT = 4, parameter int K = 4, parameter int CW = 12,
  parameter int NLVL = 7, parameter int LW = 3, parameter int TW = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      rdy_valid,
  input logic [TW-1:0]             rdy_task,
  input logic                      done_valid,
  input logic [TW-1:0]             done_task,
  input logic                      frame_go,
  input logic                      tbl_we,
  input logic                      busy,
  input logic [NT-1:0]             act,
  input logic [NT*K*(CW+LW+1)-1:0] tbl_state,
  input logic                      lvl_valid,
  input logic [TW-1:0]             lvl_task,
  input logic [LW-1:0]             lvl_out
);
  assert_lvl_follows_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> ($past(rdy_valid) && lvl_task == $past(rdy_task)));

  assert_lvl_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_valid |-> ({1'b0, lvl_out} < (LW+1)'(NLVL)));

  assert_table_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_we && busy) |=> $stable(tbl_state));

  assert_done_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && act[done_task] && !frame_go &&
     !(rdy_valid && rdy_task == done_task)) |=> !act[$past(done_task)]);
endmodule

bind dvfs_sched_lut dvfs_sched_lut_chk #(
  .NT(NT), .K(K), .CW(CW), .NLVL(NLVL), .LW(LW), .TW(TW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_valid(rdy_valid), .rdy_task(rdy_task),
  .done_valid(done_valid), .done_task(done_task), .frame_go(frame_go),
  .tbl_we(tbl_we), .busy(busy), .act(act), .tbl_state({bp, lv, ev}),
  .lvl_valid(lvl_valid), .lvl_task(lvl_task), .lvl_out(lvl_out)
);

// File: tb/test_dvfs_sched_lut.sv
module test_dvfs_sched_lut;
  localparam int NT = 4, K = 4, CW = 12, LW = 3, TW = 2, SW = 2;
  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, pred_we = 0, frame_go = 0, rdy_valid = 0, done_valid = 0;
  logic [TW-1:0] tbl_task = 0, pred_task = 0, rdy_task = 0, done_task = 0;
  logic [SW-1:0] tbl_slot = 0;
  logic [CW-1:0] tbl_ce = 0, done_cycles = 0;
  logic [LW-1:0] tbl_lvl = 0;
  logic [NT-1:0] pred_mask = 0;
  logic lvl_valid;
  logic [TW-1:0] lvl_task;
  logic [LW-1:0] lvl_out;
  logic [CW-1:0] elapsed_out;

  dvfs_sched_lut #(.NT(NT), .K(K), .CW(CW)) i_dvfs_sched_lut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int mbp [NT][K];
  int mlv [NT][K];
  bit mv  [NT][K];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lvl(input int t, input int e);
    int best = -1, bl = 0;
    for (int k = 0; k < K; k++)
      if (mv[t][k] && mbp[t][k] >= e && (best < 0 || mbp[t][k] < best)) begin
        best = mbp[t][k]; bl = mlv[t][k];
      end
    return bl;
  endfunction

  task automatic cyc(); @(negedge clk); endtask

  task automatic wr_tbl(input int t, input int s, input int ce, input int lvv, input bit model);
    tbl_we = 1; tbl_task = TW'(t); tbl_slot = SW'(s); tbl_ce = CW'(ce); tbl_lvl = LW'(lvv);
    cyc(); tbl_we = 0;
    if (model) begin mbp[t][s] = ce; mlv[t][s] = lvv; mv[t][s] = 1; end
  endtask

  task automatic wr_pred(input int t, input int m);
    pred_we = 1; pred_task = TW'(t); pred_mask = NT'(m); cyc(); pred_we = 0;
  endtask

  task automatic go(); frame_go = 1; cyc(); frame_go = 0; endtask

  task automatic done(input int t, input int c);
    done_valid = 1; done_task = TW'(t); done_cycles = CW'(c); cyc(); done_valid = 0;
  endtask

  task automatic ready(input int t, input bit ev, input int e, input string tag);
    int el;
    rdy_valid = 1; rdy_task = TW'(t); cyc(); rdy_valid = 0;
    chk(lvl_valid == ev, {tag, " valid"}, int'(lvl_valid), int'(ev));
    if (ev) begin
      chk(lvl_task == TW'(t), {tag, " task"}, int'(lvl_task), t);
      chk(elapsed_out == CW'(e), {tag, " elapsed"}, int'(elapsed_out), e);
      el = e;
      chk(lvl_out == LW'(exp_lvl(t, el)), {tag, " level"}, int'(lvl_out), exp_lvl(t, el));
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();
    for (int t = 0; t < NT; t++) for (int k = 0; k < K; k++) mv[t][k] = 0;
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0s[3] = '{40, 75, 101};
    int w1s[3] = '{60, 100, 140};
    int w2s[3] = '{0, 90, 250};
    do_reset();
    chk(lvl_valid == 0, "R1 reset lvl_valid", int'(lvl_valid), 0);
    ready(1, 1, 0, "R1 R8 empty row source");
    done(1, 5);
    do_reset();

    wr_pred(1, 1); wr_pred(2, 1); wr_pred(3, 6);
    wr_tbl(0, 0, 0, 2, 1);
    wr_tbl(1, 0, 50, 5, 1); wr_tbl(1, 1, 75, 4, 1); wr_tbl(1, 2, 100, 3, 1);
    wr_tbl(2, 0, 100, 1, 1); wr_tbl(2, 1, 75, 6, 1);
    wr_tbl(3, 0, 150, 4, 1); wr_tbl(3, 1, 200, 3, 1);
    wr_tbl(3, 2, 250, 2, 1); wr_tbl(3, 3, 300, 1, 1);

    foreach (w0s[a]) foreach (w1s[b]) foreach (w2s[c]) begin
      int j;
      go();
      ready(0, 1, 0, "R3 R7 source");
      done(0, w0s[a]);
      ready(1, 1, w0s[a], "R7 R8 branch1");
      ready(2, 1, w0s[a], "R7 R8 branch2");
      done(1, w1s[b]); done(2, w2s[c]);
      j = (w1s[b] > w2s[c]) ? w0s[a] + w1s[b] : w0s[a] + w2s[c];
      ready(3, 1, j, "R4 R7 join");
      done(3, 1);
    end

    go();
    wr_tbl(0, 1, 0, 5, 1);
    ready(0, 1, 0, "R7 tie lower slot");
    done(0, 10);
    wr_tbl(0, 0, 0, 7, 0);
    go();
    ready(0, 1, 0, "R2 level 7 write ignored");
    chk(lvl_out == 3'd2, "R2 level kept", int'(lvl_out), 2);
    wr_tbl(0, 0, 0, 6, 0);
    wr_pred(0, 8);
    done(0, 10);
    go();
    ready(0, 1, 0, "R9 write while active ignored");
    chk(lvl_out == 3'd2, "R9 level kept", int'(lvl_out), 2);
    done(0, 10);
    done(0, 500);
    ready(1, 1, 10, "R5 done of inactive ignored");
    done(1, 1);

    go();
    ready(3, 0, 0, "R6 preds not done");
    done(3, 7);
    ready(1, 0, 0, "R10 cleared done flags");
    ready(0, 1, 0, "R6 source");
    done(0, 4000);
    ready(1, 1, 4000, "R6 branch1");
    ready(2, 1, 4000, "R6 branch2");
    done(1, 500); done(2, 0);
    ready(3, 1, 4095, "R4 R8 saturated join");
    chk(lvl_out == 3'd0, "R8 fastest on overflow", int'(lvl_out), 0);
    done(3, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule